// File: doc/BRIEF.md
# Reloadable Baud Rate Divider

This block turns the system clock into the rate enables used by a serial port. A 12-bit divisor is loaded through two byte-wide write ports. One port holds the lower eight bits and the other holds the upper four. A down-counter running on every system clock produces a base tick each time it reaches zero, so the base tick rate is fclk/(divisor+1). The receiver's clock-recovery logic uses the base tick as it is.

A small phase counter divides the base tick down to one transmit bit tick. The ratio depends on the mode:

- 16 in plain asynchronous operation.
- 8 when double speed is requested.
- 2 in synchronous operation, where double speed is ignored.

When the port is the synchronous clock master, the block also drives an external serial clock. It is a square wave that flips on every base tick.

Writing the low divisor byte restarts the count at once. Writing the high byte alone is only held, and it is picked up at the next natural reload. Software should therefore write the high byte first and the low byte last. The block has no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `baud_rate_divider`

## Requirements
- R1: The divisor is {high[3:0], low[7:0]}. Outside reset, base_tick is high exactly in the cycles where the down-counter is zero. When the counter is zero and no low-byte write occurs, it reloads the divisor; otherwise it decrements. Base ticks therefore repeat every divisor+1 cycles.
- R2: A cycle with div_lo_we high loads the counter at that clock edge with the divisor formed from the new low byte and the high byte. If div_hi_we is high in the same cycle, the new high byte is used. This happens whether or not the counter was zero.
- R3: A high-byte write alone does not disturb the running count. Only div_hi_data[3:0] is stored; bits 7:4 are ignored.
- R4: In asynchronous mode (sync_mode=0, dbl_speed=0), bit_tick is high only together with base_tick, on every 16th base tick.
- R5: With sync_mode=0 and dbl_speed=1, bit_tick marks every 8th base tick.
- R6: With sync_mode=1, bit_tick marks every 2nd base tick whatever dbl_speed is.
- R7: A divisor of zero gives base_tick high in every cycle.
- R8: sclk_oe equals sync_mode AND sync_master. While it is high, sclk_out toggles on the clock edge after each base tick and holds otherwise. While it is low, sclk_out is 0, and the clock restarts from 0 when the master role is taken again.
- R9: The post-divide phase counter clears on reset and advances once per base tick. bit_tick fires when the phase is at or above ratio-1, and the phase then returns to 0. Low-byte writes do not clear the phase.
- R10: During reset, base_tick, bit_tick and sclk_out are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_we | input | 1 | Low divisor byte write strobe, forces a reload |
| div_lo_data | input | 8 | Low divisor byte |
| div_hi_we | input | 1 | High divisor byte write strobe |
| div_hi_data | input | 8 | High divisor byte, bits 3:0 used |
| dbl_speed | input | 1 | Halve the transmit post-divide in asynchronous mode |
| sync_mode | input | 1 | Synchronous operation select |
| sync_master | input | 1 | Drive the serial clock when synchronous |
| base_tick | output | 1 | Receiver-rate enable, one per divisor+1 clocks |
| bit_tick | output | 1 | Transmit bit enable after post-divide |
| sclk_out | output | 1 | Serial clock output in master mode |
| sclk_oe | output | 1 | Serial clock output enable |

## Verification
Two events can land in the same cycle: a low-byte write and the counter reaching zero on its own. In that cycle the written value must win over the natural reload, while the tick of that cycle still counts toward the post-divide phase. The bench sweeps the write strobe across every offset of a short count and sometimes pairs it with a high-byte write. A behavioural model run on every clock decides which divisor was loaded and when the following base, bit and serial-clock edges must appear.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int PD_W = 4;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'd0,
    PD_DOUBLE = 2'd1,
    PD_SYNC   = 2'd2
  } pd_mode_e;

  // Terminal phase of the transmit post-divider for each mode
  function automatic logic [PD_W-1:0] pd_last(input pd_mode_e m);
    case (m)
      PD_DOUBLE: pd_last = PD_W'(7);
      PD_SYNC:   pd_last = PD_W'(1);
      default:   pd_last = PD_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] lo_data,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] hi_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]   hi_q;
  logic [BYTE_W-1:0] lo_q;

  generate
    if (BYTE_W > HI_W) begin : g_spare
      logic unused_hi_bits;
      assign unused_hi_bits = ^hi_data[BYTE_W-1:HI_W];
    end
  endgenerate

  assign div_q = {hi_q, lo_q};

  always_comb begin
    div_next = {hi_we ? hi_data[HI_W-1:0] : hi_q,
                lo_we ? lo_data : lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= hi_data[HI_W-1:0];
      if (lo_we) lo_q <= lo_data;
    end
  end
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] reload_val,
  output logic [DIV_W-1:0] cnt_q,
  output logic             at_zero
);
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (force_load) begin
      cnt_q <= load_val;
    end else if (at_zero) begin
      cnt_q <= reload_val;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/baud_post_div.sv
module baud_post_div
  import baud_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_in,
  input  pd_mode_e mode,
  output logic     bit_tick
);
  logic [PD_W-1:0] ph_q;
  logic [PD_W-1:0] last;
  logic            wrap;

  assign last     = pd_last(mode);
  assign wrap     = (ph_q >= last);
  assign bit_tick = tick_in & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (tick_in) begin
      ph_q <= wrap ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_sclk_gen.sv
module baud_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_en,
  input  logic tick_in,
  output logic sclk
);
  logic sclk_q;

  assign sclk = drive_en & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else if (!drive_en) begin
      sclk_q <= 1'b0;
    end else if (tick_in) begin
      sclk_q <= ~sclk_q;
    end
  end
endmodule

// File: rtl/baud_rate_divider.sv
module baud_rate_divider
  import baud_div_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_lo_we,
  input  logic [BYTE_W-1:0] div_lo_data,
  input  logic              div_hi_we,
  input  logic [BYTE_W-1:0] div_hi_data,
  input  logic              dbl_speed,
  input  logic              sync_mode,
  input  logic              sync_master,
  output logic              base_tick,
  output logic              bit_tick,
  output logic              sclk_out,
  output logic              sclk_oe
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;
  pd_mode_e         pd_mode;

  always_comb begin
    if (sync_mode)      pd_mode = PD_SYNC;
    else if (dbl_speed) pd_mode = PD_DOUBLE;
    else                pd_mode = PD_NORMAL;
  end

  assign base_tick = rst_n & at_zero;
  assign sclk_oe   = sync_mode & sync_master;

  baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_we    (div_lo_we),
    .lo_data  (div_lo_data),
    .hi_we    (div_hi_we),
    .hi_data  (div_hi_data),
    .div_q    (div_q),
    .div_next (div_next)
  );

  baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_load (div_lo_we),
    .load_val   (div_next),
    .reload_val (div_q),
    .cnt_q      (cnt_q),
    .at_zero    (at_zero)
  );

  baud_post_div u_pdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (base_tick),
    .mode     (pd_mode),
    .bit_tick (bit_tick)
  );

  baud_sclk_gen u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_en (sclk_oe),
    .tick_in  (base_tick),
    .sclk     (sclk_out)
  );
endmodule

// File: rtl/baud_rate_divider_chk.sv
module baud_rate_divider_chk #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lo_we,
  input logic [BYTE_W-1:0] lo_data,
  input logic              hi_we,
  input logic [BYTE_W-1:0] hi_data,
  input logic [DIV_W-1:0]  cnt,
  input logic [DIV_W-1:0]  div_q,
  input logic              base_tick,
  input logic              bit_tick,
  input logic              sclk_out,
  input logic              sclk_oe
);
  localparam int HI_W = DIV_W - BYTE_W;

  // R2
  lo_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> cnt == $past({hi_we ? hi_data[HI_W-1:0] : div_q[DIV_W-1:BYTE_W], lo_data}));

  // R1
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && !lo_we) |=> cnt == $past(div_q));

  // R1
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !lo_we) |=> cnt == $past(cnt) - 1'b1);

  // R4
  bit_in_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && base_tick && !lo_we && !hi_we) |=> base_tick);

  // R8
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && base_tick) |=> (!sclk_oe || sclk_out != $past(sclk_out)));

  // R8
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !base_tick) |=> (!sclk_oe || $stable(sclk_out)));
endmodule

bind baud_rate_divider baud_rate_divider_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lo_we     (div_lo_we),
  .lo_data   (div_lo_data),
  .hi_we     (div_hi_we),
  .hi_data   (div_hi_data),
  .cnt       (cnt_q),
  .div_q     (div_q),
  .base_tick (base_tick),
  .bit_tick  (bit_tick),
  .sclk_out  (sclk_out),
  .sclk_oe   (sclk_oe)
);

// File: tb/baud_rate_divider_test.sv
module baud_rate_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_lo_we = 1'b0;
  logic [7:0] div_lo_data = 8'd0;
  logic       div_hi_we = 1'b0;
  logic [7:0] div_hi_data = 8'd0;
  logic       dbl_speed = 1'b0;
  logic       sync_mode = 1'b0;
  logic       sync_master = 1'b0;
  logic       base_tick, bit_tick, sclk_out, sclk_oe;

  int checks = 0;
  int errors = 0;
  int base_cnt = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_hi = 0, m_lo = 0, m_cnt = 0, m_pd = 0;
  bit m_sclk = 1'b0;

  baud_rate_divider uut (
    .clk(clk), .rst_n(rst_n),
    .div_lo_we(div_lo_we), .div_lo_data(div_lo_data),
    .div_hi_we(div_hi_we), .div_hi_data(div_hi_data),
    .dbl_speed(dbl_speed), .sync_mode(sync_mode), .sync_master(sync_master),
    .base_tick(base_tick), .bit_tick(bit_tick),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  always #5 clk = ~clk;

  function automatic int ratio();
    if (sync_mode) return 2;
    if (dbl_speed) return 8;
    return 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_cnt = 0; m_pd = 0; m_sclk = 1'b0;
    end else begin
      int r, nh, nl;
      bit b;
      r  = ratio();
      b  = (m_cnt == 0);
      nh = div_hi_we ? (div_hi_data % 16) : m_hi;
      nl = div_lo_we ? div_lo_data : m_lo;
      if (div_lo_we)  m_cnt = nh * 256 + nl;
      else if (b)     m_cnt = m_hi * 256 + m_lo;
      else            m_cnt = m_cnt - 1;
      if (b) m_pd = (m_pd >= r - 1) ? 0 : m_pd + 1;
      if (!(sync_mode && sync_master)) m_sclk = 1'b0;
      else if (b) m_sclk = !m_sclk;
      m_hi = nh;
      m_lo = nl;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit eb, eo;
      eb = rst_n && (m_cnt == 0);
      eo = sync_mode && sync_master;
      if (base_tick) base_cnt++;
      check(rst_n ? "R1 R2 R3 R7 base_tick" : "R10 base_tick", base_tick, eb);
      check(rst_n ? "R4 R5 R6 R9 bit_tick" : "R10 bit_tick", bit_tick,
            eb && (m_pd >= ratio() - 1));
      check(rst_n ? "R8 sclk_out" : "R10 sclk_out", sclk_out, eo && m_sclk);
      check("R8 sclk_oe", sclk_oe, eo);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_lo(input int v);
    div_lo_we = 1'b1; div_lo_data = v[7:0];
    step(1);
    div_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input int v);
    div_hi_we = 1'b1; div_hi_data = v[7:0];
    step(1);
    div_hi_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 R2: combined write of 0x005, base tick every 6 cycles
    div_hi_we = 1'b1; div_hi_data = 8'h00;
    div_lo_we = 1'b1; div_lo_data = 8'd5;
    step(1);
    div_hi_we = 1'b0; div_lo_we = 1'b0;
    base_cnt = 0;
    step(60);
    check("R1 tick count divisor 5", base_cnt, 10);

    // R4 normal async, then R5 double speed
    wr_lo(3);
    step(200);
    dbl_speed = 1'b1;
    step(120);

    // R6 synchronous with double speed still set; R8 master clock
    sync_mode = 1'b1; sync_master = 1'b1;
    step(60);
    dbl_speed = 1'b0;
    step(30);
    sync_master = 1'b0;
    step(20);
    sync_master = 1'b1;
    step(30);
    sync_mode = 1'b0; sync_master = 1'b0;

    // R3: high write alone held, upper bits ignored
    wr_lo(2);
    wr_hi(8'hF1);
    step(30);
    wr_lo(8'h10);
    base_cnt = 0;
    step(273 * 2);
    check("R3 R2 tick count divisor 0x110", base_cnt, 2);

    // R7: zero divisor
    wr_hi(0);
    wr_lo(0);
    base_cnt = 0;
    step(40);
    check("R7 tick every cycle", base_cnt, 40);

    // R2 R9: low writes at every offset of a short count
    wr_lo(3);
    for (int k = 0; k < 16; k++) begin
      step(k % 5);
      if (k % 4 == 0) begin
        div_hi_we = 1'b1; div_hi_data = 8'h00;
      end
      wr_lo(2 + (k % 3));
      div_hi_we = 1'b0;
    end
    step(80);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule